// File: doc/BRIEF.md
# UART Register Block with Receive Queue

This block is the memory-mapped register side of a UART controller. A processor reaches it through a simple 32-bit read/write bus inside a 4 KB window. Through that bus it sets the baud divisors, the line and control words, the FIFO level select, the interrupt mask and the DMA control word. It also reads the flag, raw-status and masked-status words and a fixed set of identification bytes. Only the register state of the DMA and IrDA words is kept; the block has no DMA, IrDA, baud generator or serial shifter.

Characters from the receiver arrive on a byte stream with a valid/ready handshake. They are stored in a 16-entry circular receive queue. Each entry is 11 bits wide, because a line-break event enters the queue as the value 0x400. When the FIFO-enable bit of the line control word is clear, the queue behaves as a single holding register. A write to the data word sends its low byte out on a transmit stream for one cycle. A single level interrupt output is the OR of the raw status bits that the mask enables.

Top module: `uart_regblk`

## Requirements
- R1: After reset the flag word (offset 0x18) reads 0x90, FIFO level select (0x34) reads 0x12, control (0x30) reads 0x300, `irq` is low and `rx_ready` is high.
- R2: The configuration words read back what was written: IrDA 0x20 (8 bits), integer baud 0x24 (16), fractional baud 0x28 (6), line control 0x2C (8), control 0x30 (16), level select 0x34 (6), mask 0x38 (11), DMA 0x48 (3). Writes to the flag word are ignored. Reads of any undefined offset return 0.
- R3: A read in 0xFE0..0xFFC returns identification byte number (offset-0xFE0)>>2. With `ID_VARIANT`=0 the bytes are 11,10,14,00,0D,F0,05,B1 (hex). With 1 they are 11,00,18,01,0D,F0,05,B1.
- R4: A write to the data word (0x00) raises `tx_valid` for exactly the next cycle, with `tx_data` equal to the written low byte. It also sets raw status bit 5 (TX).
- R5: `irq` is high exactly when raw status (0x3C) AND mask (0x38) is non-zero. Masked status (0x40) reads that AND.
- R6: A write to the interrupt clear word (0x44) clears every raw status bit that is 1 in the written value. A receive event in the same cycle still sets its bit.
- R7: With line control bit 4 set, the queue accepts entries while it holds fewer than 16. `rx_ready` is low at 16 entries. Entries are returned in arrival order across pointer wrap.
- R8: With line control bit 4 clear, the queue accepts an entry only while it is empty.
- R9: Flag bit 4 (RX empty) is set exactly when the queue is empty. Flag bit 6 (RX full) is set when the queue holds 16 entries, or when FIFO mode is off and the queue holds one entry. Flag bit 7 (TX empty) is 1 and bit 5 (TX full) is 0.
- R10: Raw status bit 4 (RX) is set when a push makes the count equal to the trigger level (1). It is cleared when a data read leaves the count at the trigger minus one. It is not cleared by reads that leave more entries.
- R11: A data read of an empty queue changes neither the count nor the pointers.
- R12: An accepted entry with `rx_brk` high is stored as 0x400, and a data read returns 0x400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| rx_valid | input | 1 | Receive entry offered |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Offered entry is a line-break event |
| rx_ready | output | 1 | Queue can accept this cycle |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the queue in FIFO mode after an earlier single access has moved the pointers off zero. A design with broken wrap would return the characters out of order, and a wrong limit would accept a seventeenth entry. In non-FIFO mode it offers a second character while one is held. A design that ignored the mode would accept it and show the wrong full flag. It checks that the RX status bit stays set through partial draining and clears only on the last read. A design that cleared on any read would drop the interrupt early. It also reads the data word while the queue is empty and then pushes one character. A count that wrapped below zero would show up as a wrong value or wrong flags.

// File: rtl/uart_regblk_pkg.sv
// Package: shared widths, word indices and bit positions for the UART
// register block. Assumes a 4 KB window addressed in 32-bit words.
package uart_regblk_pkg;
    localparam int ENTRY_W   = 11;   // queue entry: 8 data bits plus break tag at bit 10
    localparam int STAT_W    = 11;   // raw status / mask width
    localparam int ILPR_W    = 8;
    localparam int IBRD_W    = 16;
    localparam int FBRD_W    = 6;
    localparam int LCR_W     = 8;
    localparam int CTRL_W    = 16;
    localparam int IFLS_W    = 6;
    localparam int DMAC_W    = 3;

    localparam logic [9:0] WD_DATA = 10'd0;
    localparam logic [9:0] WD_FLAG = 10'd6;
    localparam logic [9:0] WD_ILPR = 10'd8;
    localparam logic [9:0] WD_IBRD = 10'd9;
    localparam logic [9:0] WD_FBRD = 10'd10;
    localparam logic [9:0] WD_LCRH = 10'd11;
    localparam logic [9:0] WD_CTRL = 10'd12;
    localparam logic [9:0] WD_IFLS = 10'd13;
    localparam logic [9:0] WD_MASK = 10'd14;
    localparam logic [9:0] WD_RAW  = 10'd15;
    localparam logic [9:0] WD_MSTA = 10'd16;
    localparam logic [9:0] WD_ICLR = 10'd17;
    localparam logic [9:0] WD_DMAC = 10'd18;

    localparam int BIT_RXST   = 4;   // status bit: receive
    localparam int BIT_TXST   = 5;   // status bit: transmit
    localparam int BIT_FIFOEN = 4;   // line control: FIFO enable
    localparam int BIT_BRK    = 10;  // break tag inside a queue entry

    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
    localparam logic [IFLS_W-1:0] IFLS_RST = 6'h12;
endpackage

// File: rtl/uart_rx_queue.sv
// Receive queue: circular store of DEPTH entries. In FIFO mode it accepts
// while count < DEPTH; otherwise only while empty (single holding entry).
// A pop with an empty queue is ignored. Assumes one push and one pop
// request at most per cycle.
module uart_rx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         push_valid,
    input  logic [W-1:0]                 push_data,
    output logic                         push_ready,
    input  logic                         pop_req,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    // accept rule depends on mode
    always_comb push_ready = fifo_en ? (count < CW'(DEPTH)) : (count == '0);

    always_comb begin
        do_push = push_valid && push_ready;
        do_pop  = pop_req && (count != '0);
        head    = store[rd_ptr];
    end

    // pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // entry storage, cleared at reset so stale reads are defined
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Interrupt control: holds raw status and mask, applies clear-by-write,
// then event sets (sets win over a same-cycle clear), drives the level irq.
module uart_irq_ctrl #(
    parameter int W    = 11,
    parameter int RXB  = 4,
    parameter int TXB  = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_tx,
    input  logic         set_rx,
    input  logic         clr_rx,
    input  logic         clr_we,
    input  logic [W-1:0] clr_val,
    input  logic         mask_we,
    input  logic [W-1:0] mask_val,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] raw_nxt;

    // next raw status: clears first, then sets
    always_comb begin
        raw_nxt = raw;
        if (clr_we) raw_nxt = raw_nxt & ~clr_val;
        if (clr_rx) raw_nxt[RXB] = 1'b0;
        if (set_tx) raw_nxt[TXB] = 1'b1;
        if (set_rx) raw_nxt[RXB] = 1'b1;
    end

    // status and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= raw_nxt;
            if (mask_we) mask <= mask_val;
        end
    end

    // level interrupt
    always_comb irq = |(raw & mask);
endmodule

// File: rtl/uart_id_rom.sv
// Identification bytes: eight constant bytes chosen by VARIANT.
module uart_id_rom #(
    parameter int VARIANT = 0
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    generate
        if (VARIANT == 0) begin : g_std
            // standard byte set
            always_comb begin
                case (idx)
                    3'd0: id_byte = 8'h11;
                    3'd1: id_byte = 8'h10;
                    3'd2: id_byte = 8'h14;
                    3'd3: id_byte = 8'h00;
                    3'd4: id_byte = 8'h0D;
                    3'd5: id_byte = 8'hF0;
                    3'd6: id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end else begin : g_alt
            // alternate byte set
            always_comb begin
                case (idx)
                    3'd0: id_byte = 8'h11;
                    3'd1: id_byte = 8'h00;
                    3'd2: id_byte = 8'h18;
                    3'd3: id_byte = 8'h01;
                    3'd4: id_byte = 8'h0D;
                    3'd5: id_byte = 8'hF0;
                    3'd6: id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/uart_regblk.sv
// UART register block top: bus decode, configuration words, flag word,
// transmit stream, receive queue and interrupt control. Reads are
// combinational from current state; all side effects take place at the
// clock edge of the access. Assumes at most one bus access per cycle.
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int RX_TRIGGER = 1,
    parameter int ID_VARIANT = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_brk,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [9:0]         word;
    logic               id_hit, rd_en, wr_en;
    logic [ILPR_W-1:0]  ilpr_q;
    logic [IBRD_W-1:0]  ibrd_q;
    logic [FBRD_W-1:0]  fbrd_q;
    logic [LCR_W-1:0]   lcr_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [IFLS_W-1:0]  ifls_q;
    logic [DMAC_W-1:0]  dmac_q;
    logic [ENTRY_W-1:0] q_in, q_head;
    logic [CW-1:0]      q_count;
    logic               fifo_en, pop_req, push_fire, pop_fire;
    int                 cnt_after;
    logic               set_rx, clr_rx, set_tx;
    logic [STAT_W-1:0]  raw, mask;
    logic [7:0]         id_byte;
    logic [7:0]         flags;
    logic               rx_full;

    // address decode
    always_comb begin
        word   = bus_addr[11:2];
        id_hit = (bus_addr[11:5] == 7'h7F);
        rd_en  = bus_sel && !bus_wr && !id_hit;
        wr_en  = bus_sel &&  bus_wr && !id_hit;
    end

    always_comb fifo_en = lcr_q[BIT_FIFOEN];

    // queue input value: break event replaces the character
    always_comb q_in = rx_brk ? ENTRY_W'(1 << BIT_BRK) : {{(ENTRY_W-8){1'b0}}, rx_data};

    always_comb pop_req = rd_en && (word == WD_DATA);

    uart_rx_queue #(.DEPTH(DEPTH), .W(ENTRY_W)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_valid (rx_valid),
        .push_data  (q_in),
        .push_ready (rx_ready),
        .pop_req    (pop_req),
        .head       (q_head),
        .count      (q_count)
    );

    // receive interrupt trigger logic on the count after this cycle
    always_comb begin
        push_fire = rx_valid && rx_ready;
        pop_fire  = pop_req && (q_count != '0);
        cnt_after = int'(q_count) + int'(push_fire) - int'(pop_fire);
        set_rx    = push_fire && (cnt_after == RX_TRIGGER);
        clr_rx    = pop_req && (cnt_after == RX_TRIGGER - 1);
        set_tx    = wr_en && (word == WD_DATA);
    end

    uart_irq_ctrl #(.W(STAT_W), .RXB(BIT_RXST), .TXB(BIT_TXST)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_tx   (set_tx),
        .set_rx   (set_rx),
        .clr_rx   (clr_rx),
        .clr_we   (wr_en && (word == WD_ICLR)),
        .clr_val  (bus_wdata[STAT_W-1:0]),
        .mask_we  (wr_en && (word == WD_MASK)),
        .mask_val (bus_wdata[STAT_W-1:0]),
        .raw      (raw),
        .mask     (mask),
        .irq      (irq)
    );

    uart_id_rom #(.VARIANT(ID_VARIANT)) u_id (
        .idx     (bus_addr[4:2]),
        .id_byte (id_byte)
    );

    // flag word from queue state; transmit side is never busy
    always_comb begin
        rx_full = (q_count == CW'(DEPTH)) || (!fifo_en && q_count != '0);
        flags   = 8'h80;
        flags[6] = rx_full;
        flags[4] = (q_count == '0);
    end

    // configuration word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ilpr_q <= '0;
            ibrd_q <= '0;
            fbrd_q <= '0;
            lcr_q  <= '0;
            ctrl_q <= CTRL_RST;
            ifls_q <= IFLS_RST;
            dmac_q <= '0;
        end else if (wr_en) begin
            case (word)
                WD_ILPR: ilpr_q <= bus_wdata[ILPR_W-1:0];
                WD_IBRD: ibrd_q <= bus_wdata[IBRD_W-1:0];
                WD_FBRD: fbrd_q <= bus_wdata[FBRD_W-1:0];
                WD_LCRH: lcr_q  <= bus_wdata[LCR_W-1:0];
                WD_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
                WD_IFLS: ifls_q <= bus_wdata[IFLS_W-1:0];
                WD_DMAC: dmac_q <= bus_wdata[DMAC_W-1:0];
                default: ;
            endcase
        end
    end

    // transmit stream: one-cycle pulse after a data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= set_tx;
            if (set_tx) tx_data <= bus_wdata[7:0];
        end
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (id_hit) begin
                bus_rdata = {24'b0, id_byte};
            end else begin
                case (word)
                    WD_DATA: bus_rdata = 32'(q_head);
                    WD_FLAG: bus_rdata = 32'(flags);
                    WD_ILPR: bus_rdata = 32'(ilpr_q);
                    WD_IBRD: bus_rdata = 32'(ibrd_q);
                    WD_FBRD: bus_rdata = 32'(fbrd_q);
                    WD_LCRH: bus_rdata = 32'(lcr_q);
                    WD_CTRL: bus_rdata = 32'(ctrl_q);
                    WD_IFLS: bus_rdata = 32'(ifls_q);
                    WD_MASK: bus_rdata = 32'(mask);
                    WD_RAW:  bus_rdata = 32'(raw);
                    WD_MSTA: bus_rdata = 32'(raw & mask);
                    WD_DMAC: bus_rdata = 32'(dmac_q);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_regblk_chk.sv
// Checker for uart_regblk: temporal properties on ports and on signals
// driven by separate submodules. Attached by bind below.
module uart_regblk_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [11:0]   bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          fifo_en,
    input logic [CW-1:0] q_count,
    input logic [10:0]   raw,
    input logic          irq
);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

    // R8
    single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && q_count != '0) |-> !rx_ready);

    // R4
    tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 12'h000) |=>
            (tx_valid && tx_data == $past(bus_wdata[7:0]) && raw[5]));

    // R10
    rx_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && q_count == '0) |=> raw[4]);

    // R6
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 12'h044 && bus_wdata[5]) |=> !raw[5]);

    // R5
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0));
endmodule

bind uart_regblk uart_regblk_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .fifo_en   (fifo_en),
    .q_count   (q_count),
    .raw       (raw),
    .irq       (irq)
);

// File: tb/sim_uart_regblk.sv
// Directed bench for uart_regblk: one task per scenario, each checking itself.
module sim_uart_regblk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_brk = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    uart_regblk u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_wrt(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] c, input logic brk, output logic took);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = c; rx_brk = brk;
        #1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(12'h018, d); check("R1 flags", d, 32'h90);
        bus_rd(12'h034, d); check("R1 level select", d, 32'h12);
        bus_rd(12'h030, d); check("R1 control", d, 32'h300);
        check("R1 irq", 32'(irq), 0);
        check("R1 rx_ready", 32'(rx_ready), 1);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_wrt(12'h024, 32'hFFFF_1234);
        bus_rd(12'h024, d); check("R2 integer baud", d, 32'h1234);
        bus_wrt(12'h028, 32'hFF);
        bus_rd(12'h028, d); check("R2 fractional baud", d, 32'h3F);
        bus_wrt(12'h048, 32'h5);
        bus_rd(12'h048, d); check("R2 dma word", d, 32'h5);
        bus_wrt(12'h018, 32'hFF);
        bus_rd(12'h018, d); check("R2 flag write ignored", d, 32'h90);
        bus_rd(12'h004, d); check("R2 undefined 0x04", d, 0);
        bus_rd(12'h100, d); check("R2 undefined 0x100", d, 0);
    endtask

    task automatic t_ident();
        logic [7:0] exp_id [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            bus_rd(12'hFE0 + 12'(i * 4), d);
            check("R3 id byte", d, 32'(exp_id[i]));
        end
    endtask

    task automatic t_tx_irq();
        logic [31:0] d;
        bus_wrt(12'h000, 32'h1A5);
        check("R4 tx_valid", 32'(tx_valid), 1);
        check("R4 tx_data", 32'(tx_data), 32'hA5);
        @(negedge clk);
        check("R4 tx_valid single", 32'(tx_valid), 0);
        bus_rd(12'h03C, d); check("R4 raw tx bit", d, 32'h20);
        check("R5 irq masked off", 32'(irq), 0);
        bus_wrt(12'h038, 32'h20);
        check("R5 irq on", 32'(irq), 1);
        bus_rd(12'h040, d); check("R5 masked status", d, 32'h20);
        bus_wrt(12'h044, 32'h20);
        check("R6 irq cleared", 32'(irq), 0);
        bus_rd(12'h03C, d); check("R6 raw cleared", d, 0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        logic took;
        rx_push(8'h41, 1'b0, took); check("R8 first accepted", 32'(took), 1);
        rx_push(8'h42, 1'b0, took); check("R8 second refused", 32'(took), 0);
        bus_rd(12'h018, d); check("R9 flags one held", d, 32'hC0);
        bus_rd(12'h03C, d); check("R10 rx raw set", d, 32'h10);
        bus_rd(12'h000, d); check("R8 held value", d, 32'h41);
        bus_rd(12'h018, d); check("R9 flags empty", d, 32'h90);
        bus_rd(12'h03C, d); check("R10 rx raw cleared", d, 0);
    endtask

    task automatic t_fifo();
        logic [31:0] d;
        logic took;
        bus_wrt(12'h02C, 32'h10);
        for (int i = 0; i < 16; i++) begin
            rx_push(8'h30 + 8'(i), 1'b0, took);
            check("R7 accept", 32'(took), 1);
        end
        rx_push(8'h7F, 1'b0, took); check("R7 refuse at 16", 32'(took), 0);
        bus_rd(12'h018, d); check("R9 flags full", d, 32'hC0);
        for (int i = 0; i < 16; i++) begin
            bus_rd(12'h000, d);
            check("R7 order", d, 32'h30 + 32'(i));
            if (i == 7) begin
                bus_rd(12'h03C, d); check("R10 raw held mid-drain", d, 32'h10);
                bus_rd(12'h018, d); check("R9 flags partial", d, 32'h80);
            end
        end
        bus_rd(12'h03C, d); check("R10 raw cleared at empty", d, 0);
        bus_rd(12'h018, d); check("R9 flags drained", d, 32'h90);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        logic took;
        bus_rd(12'h000, d);
        bus_rd(12'h018, d); check("R11 still empty", d, 32'h90);
        rx_push(8'h55, 1'b0, took); check("R11 accept after empty read", 32'(took), 1);
        bus_rd(12'h018, d); check("R11 one entry", d, 32'h80);
        bus_rd(12'h000, d); check("R11 value", d, 32'h55);
        bus_rd(12'h018, d); check("R11 empty again", d, 32'h90);
    endtask

    task automatic t_break();
        logic [31:0] d;
        logic took;
        rx_push(8'h00, 1'b1, took); check("R12 break accepted", 32'(took), 1);
        bus_rd(12'h000, d); check("R12 break value", d, 32'h400);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk) rst_n = 1'b1;
                t_reset();
                t_regs();
                t_ident();
                t_tx_irq();
                t_single();
                t_fifo();
                t_empty_read();
                t_break();
            end
            begin
                repeat (50000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule